// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Shift Register

This block holds a parallel word in a storage register and, on command, hands it to a second register that shifts it out one bit at a time. A host captures a new word into storage with a capture strobe. The serial shifter keeps emitting the previous word while that happens. A load control copies storage into the shifter. A clear control empties the shifter. Either of these controls overrides shifting. Each rising edge of the shift strobe moves the shifter one place toward its top stage and takes a new bit from the serial input into the bottom stage. The serial output is the top stage, so a loaded word leaves most significant bit first.

Both strobes are ordinary signals sampled by the system clock, and each one acts on its 0-to-1 transitions only. A strobe held high counts as a single event. When load is held active, each new capture also reaches the shifter in the same cycle, so storage and shifter move together. Load and clear active together is not a legal request. The block resolves it in favour of clear and raises a flag while the combination lasts. The strobes, controls and serial pins are plain level signals with no handshake: data is taken whenever an edge is seen, and the block never stalls its source.

Top module: `dbuf_piso_shift`

## Requirements
- R1: While rst_n is low at a clock edge, the storage register and the shifter both become zero, so ser_out reads 0 after reset.
- R2: The storage register takes par_in on the clock edge at which cap_stb is sampled 1 after having been sampled 0 on the previous edge (a 0-to-1 transition). Storage does not change at any other time, and a capture on its own leaves the shifter unchanged.
- R3: With load_n low and clr_n high, the shifter takes the storage contents on every clock edge, and any shift strobe edge in that cycle has no effect.
- R4: With clr_n low and load_n high, the shifter becomes all zeros at the clock edge, and any shift strobe edge in that cycle has no effect.
- R5: With load_n and clr_n both high, a 0-to-1 transition of shf_stb moves bit i of the shifter into bit i+1 and puts ser_in into bit 0. With no such transition the shifter holds its value.
- R6: ser_out is bit WIDTH-1 of the shifter, so a loaded word appears MSB first, one bit per shift strobe edge.
- R7: With load_n low, a capture edge delivers par_in to the shifter in that same clock edge, so the new word passes straight through.
- R8: With load_n and clr_n both low, clear wins and the shifter becomes zero. illegal_ctl is 1 exactly while both controls are low.
- R9: When capture and shift edges fall in the same cycle with both controls high, the shifter shifts its old contents. The new word stays in storage and reaches the shifter only at the next load.
- R10: A strobe held high over many cycles acts once: one capture or one shift per 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| par_in | input | WIDTH | Parallel word to capture |
| cap_stb | input | 1 | Storage capture strobe, acts on 0-to-1 transitions |
| shf_stb | input | 1 | Shift strobe, acts on 0-to-1 transitions |
| ser_in | input | 1 | Serial bit entering shifter bit 0 |
| load_n | input | 1 | Active-low copy of storage into shifter |
| clr_n | input | 1 | Active-low clear of the shifter |
| ser_out | output | 1 | Top shifter stage |
| illegal_ctl | output | 1 | High while load_n and clr_n are both low |

## Verification
The cases of interest are a capture and a shift edge in one cycle, and a capture landing during an active load. The bench raises cap_stb and shf_stb at the same negative edge, with a fresh word on par_in. The old word must keep shifting out, and the fresh word must appear only after a later load pulse. It also pulses a capture while load is held low and expects the new word at ser_out from the next cycle. A behavioural model applies the same rules and is compared with ser_out and illegal_ctl every cycle. A third overlap, clear and load together, is covered in the same way.

// File: rtl/dbuf_piso_pkg.sv
package dbuf_piso_pkg;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LOAD  = 2'd2,
    SH_CLEAR = 2'd3
  } sh_op_e;

  // clear outranks load, load outranks the shift strobe
  function automatic sh_op_e pick_op(input logic load_n,
                                     input logic clr_n,
                                     input logic shf_rise);
    sh_op_e op;
    if (!clr_n)       op = SH_CLEAR;
    else if (!load_n) op = SH_LOAD;
    else if (shf_rise) op = SH_SHIFT;
    else              op = SH_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/strb_edge.sv
module strb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stb_i;
  end

  assign rise_o = stb_i & ~prev_q;
endmodule

// File: rtl/store_reg.sv
module store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/piso_core.sv
module piso_core
  import dbuf_piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             clr_n,
  input  logic             shf_rise,
  input  logic             cap_rise,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] sh_q
);
  sh_op_e           op;
  logic [WIDTH-1:0] load_src;
  logic [WIDTH-1:0] shl;
  logic [WIDTH-1:0] nxt;

  assign op       = pick_op(load_n, clr_n, shf_rise);
  // a capture during an active load passes straight through
  assign load_src = cap_rise ? par_in : store_q;
  assign shl      = {sh_q[WIDTH-2:0], ser_in};

  always_comb begin
    unique case (op)
      SH_CLEAR: nxt = '0;
      SH_LOAD:  nxt = load_src;
      SH_SHIFT: nxt = shl;
      default:  nxt = sh_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= nxt;
  end
endmodule

// File: rtl/dbuf_piso_shift.sv
module dbuf_piso_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_stb,
  input  logic             shf_stb,
  input  logic             ser_in,
  input  logic             load_n,
  input  logic             clr_n,
  output logic             ser_out,
  output logic             illegal_ctl
);
  localparam int NSTB    = 2;
  localparam int CAP_IDX = 0;
  localparam int SHF_IDX = 1;

  logic [NSTB-1:0]  stb_vec;
  logic [NSTB-1:0]  rise_vec;
  logic             cap_edge;
  logic             shf_edge;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] sh_q;

  assign stb_vec[CAP_IDX] = cap_stb;
  assign stb_vec[SHF_IDX] = shf_stb;

  for (genvar g = 0; g < NSTB; g++) begin : g_edge
    strb_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (stb_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  assign cap_edge = rise_vec[CAP_IDX];
  assign shf_edge = rise_vec[SHF_IDX];

  store_reg #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cap_edge),
    .d_i   (par_in),
    .q_o   (store_q)
  );

  piso_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .clr_n    (clr_n),
    .shf_rise (shf_edge),
    .cap_rise (cap_edge),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .store_q  (store_q),
    .sh_q     (sh_q)
  );

  assign ser_out     = sh_q[WIDTH-1];
  assign illegal_ctl = ~load_n & ~clr_n;
endmodule

// File: rtl/dbuf_piso_chk.sv
module dbuf_piso_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             clr_n,
  input logic             ser_in,
  input logic             illegal_ctl,
  input logic [WIDTH-1:0] par_in,
  input logic             cap_edge,
  input logic             shf_edge,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] sh_q
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (sh_q == '0 && store_q == '0));

  // R2
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_edge |=> $stable(store_q));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n && !cap_edge) |=> sh_q == $past(store_q));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> sh_q == '0);

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && shf_edge) |=>
      sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

  // R5
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !shf_edge) |=> $stable(sh_q));

  // R7
  flow_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n && cap_edge) |=> sh_q == $past(par_in));

  // R8
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ctl |=> sh_q == '0);
endmodule

bind dbuf_piso_shift dbuf_piso_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_n      (load_n),
  .clr_n       (clr_n),
  .ser_in      (ser_in),
  .illegal_ctl (illegal_ctl),
  .par_in      (par_in),
  .cap_edge    (cap_edge),
  .shf_edge    (shf_edge),
  .store_q     (store_q),
  .sh_q        (sh_q)
);

// File: tb/dbuf_piso_shift_bench.sv
module dbuf_piso_shift_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         cap_stb = 1'b0;
  logic         shf_stb = 1'b0;
  logic         ser_in = 1'b0;
  logic         load_n = 1'b1;
  logic         clr_n = 1'b1;
  logic         ser_out;
  logic         illegal_ctl;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";

  // behavioural reference
  int m_store = 0;
  int m_sh = 0;
  bit m_pc = 0;
  bit m_ps = 0;

  always #2.5 clk = ~clk;

  dbuf_piso_shift #(.WIDTH(W)) u_dbuf_piso_shift (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_stb(cap_stb),
    .shf_stb(shf_stb), .ser_in(ser_in), .load_n(load_n), .clr_n(clr_n),
    .ser_out(ser_out), .illegal_ctl(illegal_ctl)
  );

  always @(posedge clk) begin
    bit cr, sr;
    if (!rst_n) begin
      m_store = 0; m_sh = 0; m_pc = 0; m_ps = 0;
    end else begin
      cr = cap_stb && !m_pc;
      sr = shf_stb && !m_ps;
      m_pc = cap_stb;
      m_ps = shf_stb;
      if (!clr_n)       m_sh = 0;
      else if (!load_n) m_sh = cr ? int'(par_in) : m_store;
      else if (sr)      m_sh = ((m_sh * 2) + int'(ser_in)) % 256;
      if (cr) m_store = int'(par_in);
    end
  end

  task automatic cmp(input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // one cycle: check outputs, then apply the next inputs
  task automatic step(input bit cap, input bit shf, input bit ld_n,
                      input bit cl_n, input bit sin, input logic [W-1:0] d);
    @(negedge clk);
    cmp("ser_out", ser_out, 1'((m_sh >> (W-1)) & 1));
    cap_stb = cap; shf_stb = shf; load_n = ld_n; clr_n = cl_n;
    ser_in = sin; par_in = d;
    #1;
    cmp("illegal_ctl", illegal_ctl, !ld_n && !cl_n);
  endtask

  task automatic shift_out(input int n, input logic [W-1:0] pat);
    for (int i = 0; i < n; i++) begin
      step(0, 1, 1, 1, pat[i], 8'h00);
      step(0, 0, 1, 1, 0, 8'h00);
    end
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, 8'hFF);
    rst_n = 1'b1;
    step(0, 0, 1, 1, 0, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);

    // R2: capture only touches storage
    req = "R2";
    step(1, 0, 1, 1, 0, 8'hA5);
    step(0, 0, 1, 1, 0, 8'h11);
    step(0, 0, 1, 1, 0, 8'h22);

    // R3: load pulse with a shift strobe edge alongside
    req = "R3";
    step(0, 1, 0, 1, 1, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);

    // R6 / R5: MSB-first drain with a serial pattern fed in
    req = "R6";
    shift_out(8, 8'b1100_1010);
    req = "R5";
    shift_out(8, 8'b0000_0000);

    // R10: strobes held high act once
    req = "R10";
    step(1, 0, 1, 1, 0, 8'h81);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 0, 8'h7E);
    step(0, 0, 0, 1, 0, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 1, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);
    shift_out(3, 8'h00);

    // R7: capture during held load flows through
    req = "R7";
    step(0, 0, 0, 1, 0, 8'h00);
    step(1, 0, 0, 1, 0, 8'h3C);
    step(0, 1, 0, 1, 0, 8'hC3);
    step(1, 0, 0, 1, 0, 8'hC3);
    step(0, 0, 1, 1, 0, 8'h00);
    shift_out(4, 8'h0F);

    // R4: clear beats shifting
    req = "R4";
    step(0, 1, 1, 0, 1, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);
    shift_out(2, 8'h00);

    // R8: both controls low
    req = "R8";
    step(0, 0, 0, 1, 0, 8'h00);
    step(0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);

    // R9: capture and shift edges together
    req = "R9";
    step(0, 0, 0, 1, 0, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);
    step(1, 1, 1, 1, 0, 8'h5A);
    step(0, 0, 1, 1, 0, 8'h00);
    shift_out(7, 8'h00);
    step(0, 0, 0, 1, 0, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);
    shift_out(8, 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL %s watchdog expired got hang expected finish", req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule